// File: doc/BRIEF.md
# Four-Channel Byte-Wide DMA Register Core

This block is the register and bookkeeping core of a four-channel, 8-bit DMA controller. Software programs each channel through a byte-wide I/O port. Each channel has a 16-bit start address, a 16-bit transfer count, an 8-bit upper address byte, a two-bit transfer mode and a mask bit. The 16-bit address and count values are written and read one byte at a time. A single low/high byte pointer, shared by all channels, selects which byte each access touches.

A peripheral moves data through a simple transfer port. It names a channel and a byte count. One cycle later the core answers with the number of bytes granted, the 24-bit memory address of the first byte, and a terminal-count flag. The core then advances the channel's current address and reduces its remaining count. After software writes a new address or count, the channel is marked for reload. The reload itself happens on the channel's next transfer.

Each channel drives an enable output. A peripheral can watch this output to learn whether the channel will accept transfers. Terminal-count events are collected in a status register, and a read of that register clears them.

Top module: `dmac4_core`

## Requirements
- R1: Each write or read of a channel address register (offset 2·ch) or count register (offset 2·ch+1) uses the shared byte pointer. The pointer selects the low byte when it is 0 and the high byte when it is 1, and it toggles after every such access. After reset the pointer is 0.
- R2: Any write to offset 0x0C returns the byte pointer to 0 (the low byte), whatever its previous state.
- R3: A write to offset 0x0A sets the mask of the channel selected by data bits [1:0] to data bit 2, where 1 means masked. Setting the mask makes that channel's enable 0 in the next cycle. All channels come out of reset masked.
- R4: A write to offset 0x0B selects a channel with data bits [1:0] and stores data bits [7:6] as that channel's transfer mode: 0 is demand, 1 is single and 2 is block. The mode appears on `chan_mode[2·ch+1:2·ch]`.
- R5: Any write to a channel's address or count register marks the channel for reload. The next transfer that moves data first loads remaining count = programmed count + 1 and current address = (upper byte << 16) + programmed address.
- R6: When a transfer requests fewer bytes than remain, the grant equals the request, `xfer_tc` is 0, and `xfer_addr` is the current address. The current address then increases by the grant and the remaining count decreases by it.
- R7: When a transfer requests at least as many bytes as remain, and at least one byte remains, the grant equals the remaining count and `xfer_tc` is 1. The channel's status bit is set, the remaining count becomes 0, and the channel's enable drops.
- R8: A channel's enable is 1 exactly when the channel is unmasked and either has a nonzero remaining count or has a reload pending. Clearing the mask re-applies this rule.
- R9: The upper address bytes of channels 0, 1, 2 and 3 are read and written at I/O addresses 0x87, 0x83, 0x81 and 0x82 respectively.
- R10: A transfer on a masked channel, with a zero byte count, or with nothing remaining is acknowledged with a grant of 0 and leaves the channel state unchanged.
- R11: A read of offset 0x08 returns the terminal-count bits of channels 3..0 in data bits [3:0] and clears them.
- R12: Reading an address or count register returns the corresponding byte of the channel's current address or remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Register write strobe, one cycle per byte |
| io_rd | input | 1 | Register read strobe, one cycle per byte; side effects occur at the clock edge |
| io_addr | input | 8 | Register I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| xfer_req | input | 1 | Transfer request, one cycle |
| xfer_chan | input | 2 | Channel for the transfer |
| xfer_len | input | 16 | Bytes requested |
| xfer_ack | output | 1 | Transfer answer valid, one cycle after the request |
| xfer_grant | output | 17 | Bytes granted |
| xfer_addr | output | 24 | Memory address of the first granted byte |
| xfer_tc | output | 1 | Transfer reached terminal count |
| chan_en | output | 4 | Per-channel enable |
| chan_mode | output | 8 | Per-channel transfer mode, two bits per channel |

## Verification
Some rules can be stated from one cycle to the next, and assertions check these on every cycle:
- A mask write drops the enable.
- A grant never exceeds the request.
- A terminal count leaves the remaining count at zero and the status bit set.
- A blocked transfer leaves the channel state stable.
- Clearing the byte pointer and clearing the status register both take effect on the next cycle.

Other behaviour shows only across whole programming and transfer scenarios, and only the bench can check it. That covers the low-then-high byte order, the lazy reload that forms the 24-bit address from the upper byte, and the exact split of a request into a partial grant and a final grant. It also covers readback of the current values and the page-port mapping. The bench sweeps every channel over several counts, including the single-byte case, and every mode value.

// File: rtl/dmac4_pkg.sv
package dmac4_pkg;
    localparam int NCH   = 4;
    localparam int CH_W  = 2;
    localparam int AW    = 16;
    localparam int CW    = 16;
    localparam int PW    = 8;
    localparam int FW    = AW + PW;
    localparam int RW    = CW + 1;
    localparam int MW    = 2;

    localparam logic [3:0] OFS_STATUS = 4'h8;
    localparam logic [3:0] OFS_MASK   = 4'hA;
    localparam logic [3:0] OFS_MODE   = 4'hB;
    localparam logic [3:0] OFS_PTRCLR = 4'hC;

    typedef struct packed {
        logic [AW-1:0] base_addr;
        logic [CW-1:0] base_cnt;
        logic [PW-1:0] page;
        logic [FW-1:0] cur_addr;
        logic [RW-1:0] cur_cnt;
        logic          reload;
        logic          masked;
        logic [MW-1:0] mode;
    } chan_state_t;

    typedef struct packed {
        logic [NCH-1:0] sel_addr;
        logic [NCH-1:0] sel_cnt;
        logic [NCH-1:0] sel_page;
        logic           sel_status;
        logic           sel_mask;
        logic           sel_mode;
        logic           sel_ptrclr;
    } io_sel_t;

    typedef struct packed {
        logic           ptr;
        logic [NCH-1:0] status;
        logic           ack;
        logic [CH_W-1:0] chan;
        logic [RW-1:0]  grant;
        logic [FW-1:0]  addr;
        logic           tc;
    } top_state_t;

    function automatic logic [7:0] page_port(input int ch);
        case (ch)
            0:       return 8'h87;
            1:       return 8'h83;
            2:       return 8'h81;
            default: return 8'h82;
        endcase
    endfunction
endpackage

// File: rtl/dmac4_decode.sv
module dmac4_decode
    import dmac4_pkg::*;
(
    input  logic [7:0] io_addr,
    output io_sel_t    sel
);
    logic ctl_hit;
    assign ctl_hit = (io_addr[7:4] == 4'h0);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign sel.sel_addr[i] = ctl_hit && (io_addr[3:0] == 4'(2 * i));
        assign sel.sel_cnt[i]  = ctl_hit && (io_addr[3:0] == 4'(2 * i + 1));
        assign sel.sel_page[i] = (io_addr == page_port(i));
    end

    assign sel.sel_status = ctl_hit && (io_addr[3:0] == OFS_STATUS);
    assign sel.sel_mask   = ctl_hit && (io_addr[3:0] == OFS_MASK);
    assign sel.sel_mode   = ctl_hit && (io_addr[3:0] == OFS_MODE);
    assign sel.sel_ptrclr = ctl_hit && (io_addr[3:0] == OFS_PTRCLR);
endmodule

// File: rtl/dmac4_chan.sv
module dmac4_chan
    import dmac4_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          wr_page,
    input  logic          hi_sel,
    input  logic [7:0]    wdata,
    input  logic          mask_wr,
    input  logic          mask_val,
    input  logic          mode_wr,
    input  logic [MW-1:0] mode_val,
    input  logic          go,
    input  logic [CW-1:0] len,
    output logic [FW-1:0] cur_addr,
    output logic [RW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output logic [MW-1:0] mode,
    output logic          en,
    output logic [RW-1:0] grant,
    output logic [FW-1:0] start_addr,
    output logic          tc
);
    chan_state_t st_d, st_q;
    logic [RW-1:0] eff_cnt;
    logic [FW-1:0] eff_addr;
    logic          usable;

    always_comb begin
        eff_cnt  = st_q.reload ? ({1'b0, st_q.base_cnt} + RW'(1)) : st_q.cur_cnt;
        eff_addr = st_q.reload ? ((FW'(st_q.page) << AW) | FW'(st_q.base_addr)) : st_q.cur_addr;
        usable   = !st_q.masked && (len != '0) && (eff_cnt != '0);
        grant    = '0;
        tc       = 1'b0;
        if (usable) begin
            if (eff_cnt <= {1'b0, len}) begin
                grant = eff_cnt;
                tc    = 1'b1;
            end else begin
                grant = {1'b0, len};
            end
        end
        start_addr = eff_addr;

        st_d = st_q;
        if (go && usable) begin
            st_d.cur_addr = eff_addr + FW'(grant);
            st_d.cur_cnt  = eff_cnt - grant;
            st_d.reload   = 1'b0;
        end
        if (wr_addr) begin
            if (hi_sel) st_d.base_addr[15:8] = wdata;
            else        st_d.base_addr[7:0]  = wdata;
            st_d.reload = 1'b1;
        end
        if (wr_cnt) begin
            if (hi_sel) st_d.base_cnt[15:8] = wdata;
            else        st_d.base_cnt[7:0]  = wdata;
            st_d.reload = 1'b1;
        end
        if (wr_page) st_d.page   = wdata;
        if (mask_wr) st_d.masked = mask_val;
        if (mode_wr) st_d.mode   = mode_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr = st_q.cur_addr;
    assign cur_cnt  = st_q.cur_cnt;
    assign page     = st_q.page;
    assign mode     = st_q.mode;
    assign en       = !st_q.masked && ((st_q.cur_cnt != '0) || st_q.reload);

    // R3
    mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_val) |=> !en);
    // R6
    grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (grant <= {1'b0, len}));
    // R7
    tc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && tc && !wr_addr && !wr_cnt) |=> (cur_cnt == '0) && !en);
    // R5
    reload_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_addr || wr_cnt) && !mask_wr && !st_q.masked) |=> en);
    // R10
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st_q.masked) |=> ($stable(cur_cnt) && $stable(cur_addr)));
endmodule

// File: rtl/dmac4_core.sv
module dmac4_core
    import dmac4_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        xfer_req,
    input  logic [1:0]  xfer_chan,
    input  logic [15:0] xfer_len,
    output logic        xfer_ack,
    output logic [16:0] xfer_grant,
    output logic [23:0] xfer_addr,
    output logic        xfer_tc,
    output logic [3:0]  chan_en,
    output logic [7:0]  chan_mode
);
    io_sel_t    sel;
    top_state_t ts_d, ts_q;

    logic [FW-1:0] c_addr  [NCH];
    logic [RW-1:0] c_cnt   [NCH];
    logic [PW-1:0] c_page  [NCH];
    logic [RW-1:0] c_grant [NCH];
    logic [FW-1:0] c_start [NCH];
    logic [NCH-1:0] c_tc;

    dmac4_decode u_decode (
        .io_addr (io_addr),
        .sel     (sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic [MW-1:0] mode_o;
        dmac4_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr    (io_wr && sel.sel_addr[i]),
            .wr_cnt     (io_wr && sel.sel_cnt[i]),
            .wr_page    (io_wr && sel.sel_page[i]),
            .hi_sel     (ts_q.ptr),
            .wdata      (io_wdata),
            .mask_wr    (io_wr && sel.sel_mask && (io_wdata[1:0] == CH_W'(i))),
            .mask_val   (io_wdata[2]),
            .mode_wr    (io_wr && sel.sel_mode && (io_wdata[1:0] == CH_W'(i))),
            .mode_val   (io_wdata[7:6]),
            .go         (xfer_req && (xfer_chan == CH_W'(i))),
            .len        (xfer_len),
            .cur_addr   (c_addr[i]),
            .cur_cnt    (c_cnt[i]),
            .page       (c_page[i]),
            .mode       (mode_o),
            .en         (chan_en[i]),
            .grant      (c_grant[i]),
            .start_addr (c_start[i]),
            .tc         (c_tc[i])
        );
        assign chan_mode[MW*i +: MW] = mode_o;
    end

    always_comb begin
        io_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel.sel_addr[i]) io_rdata = ts_q.ptr ? c_addr[i][15:8] : c_addr[i][7:0];
            if (sel.sel_cnt[i])  io_rdata = ts_q.ptr ? c_cnt[i][15:8]  : c_cnt[i][7:0];
            if (sel.sel_page[i]) io_rdata = c_page[i];
        end
        if (sel.sel_status) io_rdata = 8'(ts_q.status);
    end

    always_comb begin
        ts_d       = ts_q;
        ts_d.ack   = xfer_req;
        ts_d.chan  = xfer_chan;
        ts_d.grant = xfer_req ? c_grant[xfer_chan] : '0;
        ts_d.addr  = xfer_req ? c_start[xfer_chan] : '0;
        ts_d.tc    = xfer_req && c_tc[xfer_chan];
        if (io_rd && sel.sel_status) ts_d.status = '0;
        if (xfer_req && c_tc[xfer_chan]) ts_d.status[xfer_chan] = 1'b1;
        if ((io_wr || io_rd) && ((|sel.sel_addr) || (|sel.sel_cnt))) ts_d.ptr = !ts_q.ptr;
        if (io_wr && sel.sel_ptrclr) ts_d.ptr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign xfer_ack   = ts_q.ack;
    assign xfer_grant = ts_q.grant;
    assign xfer_addr  = ts_q.addr;
    assign xfer_tc    = ts_q.tc;

    // R2
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel.sel_ptrclr) |=> !ts_q.ptr);
    // R11
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && sel.sel_status && !xfer_req) |=> (ts_q.status == '0));
    // R7
    tc_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && xfer_tc) |-> ts_q.status[ts_q.chan]);
    // R1
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !sel.sel_ptrclr && ((|sel.sel_addr) || (|sel.sel_cnt))) |=> (ts_q.ptr != $past(ts_q.ptr)));
endmodule

// File: tb/dmac4_core_bench.sv
module dmac4_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_addr = '0, io_wdata = '0, io_rdata;
    logic        xfer_req = 1'b0;
    logic [1:0]  xfer_chan = '0;
    logic [15:0] xfer_len = '0;
    logic        xfer_ack, xfer_tc;
    logic [16:0] xfer_grant;
    logic [23:0] xfer_addr;
    logic [3:0]  chan_en;
    logic [7:0]  chan_mode;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmac4_core u_dmac4_core (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_req(xfer_req),
        .xfer_chan(xfer_chan), .xfer_len(xfer_len), .xfer_ack(xfer_ack),
        .xfer_grant(xfer_grant), .xfer_addr(xfer_addr), .xfer_tc(xfer_tc),
        .chan_en(chan_en), .chan_mode(chan_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); io_rd = 1'b1; io_addr = a;
        #2 d = io_rdata;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic xfer(input logic [1:0] ch, input logic [15:0] n);
        @(negedge clk); xfer_req = 1'b1; xfer_chan = ch; xfer_len = n;
        @(negedge clk); xfer_req = 1'b0;
    endtask

    function automatic logic [7:0] pport(input int ch);
        case (ch)
            0: return 8'h87;
            1: return 8'h83;
            2: return 8'h81;
            default: return 8'h82;
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, b2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(chan_en == 4'h0, "R3 reset masked", chan_en, 0);
        rd(8'h08, b);
        chk(b == 8'h00, "R11 reset status", b, 0);

        // R9 page ports
        for (int ch = 0; ch < 4; ch++) wr(pport(ch), 8'h50 + 8'(ch));
        for (int ch = 0; ch < 4; ch++) begin
            rd(pport(ch), b);
            chk(b == 8'h50 + 8'(ch), "R9 page readback", b, 8'h50 + 8'(ch));
        end

        // R4 mode sweep
        for (int ch = 0; ch < 4; ch++) begin
            for (int m = 0; m < 3; m++) begin
                wr(8'h0B, {2'(m), 4'b0, 2'(ch)});
                chk(chan_mode[2*ch +: 2] == 2'(m), "R4 mode field", chan_mode, m);
            end
        end

        // main sweep
        for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 3; k++) begin
                logic [15:0] base, cnt, l1;
                logic [16:0] rem;
                logic [7:0]  pg;
                logic [23:0] start;
                cnt   = (k == 0) ? 16'd0 : (k == 1) ? 16'd5 : 16'd300;
                base  = 16'h1000 * 16'(ch + 1) + 16'h0101 * 16'(k);
                pg    = 8'h20 + 8'h11 * 8'(ch) + 8'(k);
                start = {pg, base};
                rem   = {1'b0, cnt} + 17'd1;
                l1    = rem[16:1];

                // R2: stray byte leaves pointer high, then cleared
                wr(8'(2*ch), 8'hEE);
                wr(8'h0C, 8'h00);
                // R1: low then high
                wr(8'(2*ch), base[7:0]);   wr(8'(2*ch), base[15:8]);
                wr(8'(2*ch+1), cnt[7:0]);  wr(8'(2*ch+1), cnt[15:8]);
                wr(pport(ch), pg);
                wr(8'h0A, 8'(ch));
                chk(chan_en[ch] == 1'b1, "R8 enable after unmask with reload", chan_en, 1);

                if (l1 == 16'd0) begin
                    xfer(2'(ch), 16'd0);
                    chk(xfer_ack && xfer_grant == 17'd0, "R10 zero length", xfer_grant, 0);
                    chk(chan_en[ch] == 1'b1, "R8 reload still pending", chan_en, 1);
                end else begin
                    xfer(2'(ch), l1);
                    chk(xfer_grant == {1'b0, l1}, "R6 partial grant", xfer_grant, l1);
                    chk(xfer_addr == start, "R5 R1 R2 reload address", xfer_addr, start);
                    chk(xfer_tc == 1'b0, "R6 no tc", xfer_tc, 0);
                    wr(8'h0C, 8'h00);
                    rd(8'(2*ch+1), b); rd(8'(2*ch+1), b2);
                    chk({b2, b} == 16'(rem - 17'(l1)), "R12 count readback", {b2, b}, rem - 17'(l1));
                    rd(8'(2*ch), b); rd(8'(2*ch), b2);
                    chk({b2, b} == base + l1, "R12 address readback", {b2, b}, base + l1);
                end

                xfer(2'(ch), 16'hFFFF);
                chk(xfer_grant == rem - 17'(l1), "R7 final grant", xfer_grant, rem - 17'(l1));
                chk(xfer_addr == start + 24'(l1), "R7 final address", xfer_addr, start + 24'(l1));
                chk(xfer_tc == 1'b1, "R7 tc flag", xfer_tc, 1);
                chk(chan_en[ch] == 1'b0, "R7 enable dropped", chan_en, 0);
                rd(8'h08, b);
                chk(b == 8'(1 << ch), "R11 status bit", b, 1 << ch);
                rd(8'h08, b);
                chk(b == 8'h00, "R11 status cleared", b, 0);
                xfer(2'(ch), 16'd4);
                chk(xfer_grant == 17'd0 && !xfer_tc, "R10 nothing remaining", xfer_grant, 0);

                wr(8'h0C, 8'h00);
                wr(8'(2*ch+1), cnt[7:0]); wr(8'(2*ch+1), cnt[15:8]);
                chk(chan_en[ch] == 1'b1, "R5 reload enables", chan_en, 1);
                wr(8'h0A, 8'(4 | ch));
                chk(chan_en[ch] == 1'b0, "R3 mask drops enable", chan_en, 0);
                xfer(2'(ch), 16'd2);
                chk(xfer_grant == 17'd0, "R10 masked transfer", xfer_grant, 0);
                wr(8'h0A, 8'(ch));
                chk(chan_en[ch] == 1'b1, "R8 unmask re-evaluates", chan_en, 1);
                xfer(2'(ch), 16'd1);
                chk(xfer_grant == 17'd1 && xfer_addr == start && xfer_tc == (cnt == 16'd0),
                    "R5 reload after mask", xfer_addr, start);
                rd(8'h08, b);
                wr(8'h0A, 8'(4 | ch));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule